// File: doc/BRIEF.md
# Distance-Ordered Bankset Cache Controller

This controller manages one set that is spread over several cache banks. Each bank sits at a different distance from the requester, so the banks answer after different numbers of cycles. Position 0 is the nearest bank and position NB-1 is the farthest. The controller holds SETS such sets, and each one has its own line order. A request picks a set, gives a full tag, and is either a read or a fill.

A read looks up the addressed set in every bank at once. If the tag is found in bank i, the response comes back after the latency of that bank. After that, the line trades places with its nearer neighbour, so it moves one position closer on each hit. A small array of partial tags holds the low tag bits of every position of every set. When none of those partial tags matches, the controller reports the miss almost at once instead of waiting for the farthest bank. A fill always writes into the farthest bank, and the line that was there is discarded. Misses are only reported; fetching the missing line is left to the requester.

Top module: `nuca_bankset_ctrl`

## Requirements
- R1: A read that finds its full tag in bank i produces a one-cycle `rsp_valid` pulse exactly BASE+i*STEP cycles after the clock edge that accepted it. With the pulse come `rsp_hit`=1, `rsp_bank`=i and the data stored with the line.
- R2: In this case `rsp_hit`=0, `rsp_early`=0, `rsp_bank`=0 and `rsp_data`=0, and the response comes at the farthest-bank latency BASE+(NB-1)*STEP. The case is a read whose low PTW tag bits match some valid line of the set while no full tag matches. A partial-tag match alone is never a hit.
- R3: In this case the response comes one cycle after acceptance, with `rsp_hit`=0 and `rsp_early`=1. The case is a read whose low PTW tag bits match no valid line of the set.
- R4: After a hit in bank k>0, the line from bank k and the line from bank k-1 have traded positions. Later reads then find each of them at its new bank.
- R5: A hit in bank 0 moves nothing, and `req_ready` is high in the cycle after the response.
- R6: After a hit in bank k>0, `req_ready` is low for exactly one cycle, the cycle after the response, and then high again.
- R7: A fill (`req_fill`=1) is accepted in one cycle. It writes tag and data into the farthest bank of the set, raises no response, and leaves `req_ready` high.
- R8: A fill discards the line that was in the farthest bank. A later read of the discarded tag misses.
- R9: Reads and fills of one set never change the contents or order of another set.
- R10: After reset every line is invalid, `req_ready` is high, `rsp_valid` is low, and any read misses early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_fill | input | 1 | 1 = fill, 0 = read |
| req_set | input | SETW | Set index |
| req_tag | input | TAGW | Full tag |
| req_data | input | DATAW | Fill data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_hit | output | 1 | Full-tag hit |
| rsp_early | output | 1 | Miss declared by the partial-tag filter |
| rsp_bank | output | BW | Bank that served the hit |
| rsp_data | output | DATAW | Line data on a hit |

## Verification
The bench walks one line from the farthest bank to the nearest. It checks the bank number and the exact latency at every step, so a swap made in the wrong direction, or a latency counted from the wrong bank, shows up as a wrong `rsp_bank` or a wrong cycle count. Some reads share low tag bits with a resident line but differ in the full tag. A design that treats a partial match as a hit would report a false hit there, and one that ignores the filter would report every miss late. Directed steps check the one-cycle stall after a promotion and its absence after a bank-0 hit. They also check eviction by a fill, isolation between sets, and the state after reset. A design that skips the stall, or that disturbs a neighbouring set, breaks the order the bench predicts.

// File: rtl/nuca_pkg.sv
// Shared types for the bankset controller.
// Holds the sequencer state encoding. Widths are kept as module parameters.
package nuca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SWAP = 2'd2
    } nuca_state_e;
endpackage

// File: rtl/nuca_bank.sv
// One cache bank: each of its SETS entries holds one line (valid bit, tag, data).
// Assumes: reads are combinational at rd_set, and the full-tag compare runs
// against lk_tag at that same set. Writes take effect at the clock edge.
// Reset invalidates every entry; tag and data are left unreset.
module nuca_bank #(
    parameter int SETS  = 4,
    parameter int TAGW  = 12,
    parameter int DATAW = 16,
    localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SETW-1:0]  rd_set,
    input  logic [TAGW-1:0]  lk_tag,
    output logic             lk_hit,
    output logic             rd_valid,
    output logic [TAGW-1:0]  rd_tag,
    output logic [DATAW-1:0] rd_data,
    input  logic             wr_en,
    input  logic [SETW-1:0]  wr_set,
    input  logic             wr_valid,
    input  logic [TAGW-1:0]  wr_tag,
    input  logic [DATAW-1:0] wr_data
);
    logic [SETS-1:0]  valid_q;
    logic [TAGW-1:0]  tag_q  [SETS];
    logic [DATAW-1:0] data_q [SETS];

    // Valid bits: cleared by reset, written along with the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set] <= wr_valid;
        end
    end

    // Tag and data storage: no reset needed, qualified by the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            data_q[wr_set] <= wr_data;
        end
    end

    // Read port and full-tag compare.
    always_comb begin
        rd_valid = valid_q[rd_set];
        rd_tag   = tag_q[rd_set];
        rd_data  = data_q[rd_set];
        lk_hit   = rd_valid && (rd_tag == lk_tag);
    end
endmodule

// File: rtl/nuca_ptag.sv
// Partial-tag filter: holds the low PTW tag bits, plus a valid bit, for every
// bank position of every set.
// Assumes: it is written with the same per-position enables and set as the
// banks, so it always mirrors their order. any_match is combinational.
module nuca_ptag #(
    parameter int SETS = 4,
    parameter int NB   = 4,
    parameter int PTW  = 4,
    localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SETW-1:0]         rd_set,
    input  logic [PTW-1:0]          lk_ptag,
    output logic                    any_match,
    input  logic [NB-1:0]           wr_en,
    input  logic [SETW-1:0]         wr_set,
    input  logic [NB-1:0]           wr_valid,
    input  logic [NB-1:0][PTW-1:0]  wr_ptag
);
    logic [NB-1:0]          pv_q [SETS];
    logic [NB-1:0][PTW-1:0] pt_q [SETS];

    // Valid bits per position: cleared on reset, updated by each position's enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                pv_q[s] <= '0;
            end
        end else begin
            for (int p = 0; p < NB; p++) begin
                if (wr_en[p]) begin
                    pv_q[wr_set][p] <= wr_valid[p];
                end
            end
        end
    end

    // Partial tag bits per position.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NB; p++) begin
            if (wr_en[p]) begin
                pt_q[wr_set][p] <= wr_ptag[p];
            end
        end
    end

    // Match any valid partial tag in the addressed set.
    always_comb begin
        any_match = 1'b0;
        for (int p = 0; p < NB; p++) begin
            if (pv_q[rd_set][p] && (pt_q[rd_set][p] == lk_ptag)) begin
                any_match = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nuca_seq.sv
// Request sequencer: idle -> wait for the chosen latency -> optional swap cycle.
// Assumes: start is only raised while idle. tgt is at least 1. promote is
// stable from the response cycle on.
module nuca_seq
    import nuca_pkg::*;
#(
    parameter int LATW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LATW-1:0] tgt,
    input  logic            promote,
    output nuca_state_e     state,
    output logic            rsp_fire,
    output logic            swap_go
);
    logic [LATW-1:0] cnt_q;
    logic [LATW-1:0] tgt_q;

    // State and latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
            tgt_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_WAIT;
                        cnt_q <= LATW'(1);
                        tgt_q <= tgt;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == tgt_q) begin
                        state <= promote ? ST_SWAP : ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + LATW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Response pulse and swap strobe.
    always_comb begin
        rsp_fire = (state == ST_WAIT) && (cnt_q == tgt_q);
        swap_go  = (state == ST_SWAP);
    end

    AST_SWAP_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |-> $past(rsp_fire)) else $error("swap without response"); // R4
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fire |=> !rsp_fire) else $error("response longer than one cycle"); // R1
endmodule

// File: rtl/nuca_bankset_ctrl.sv
// Distance-ordered bankset controller (top).
// NB banks are probed in parallel. The response waits for the latency of the
// bank that hit (BASE+i*STEP), or for the farthest-bank latency on a miss. A
// miss that the partial-tag filter catches is reported one cycle after
// acceptance. A hit in bank k>0 swaps lines k and k-1 in one cycle after the
// response, and new requests are held off during that cycle. Fills go to the
// farthest bank.
// Assumes: a fill never carries a tag that is already present in its set.
module nuca_bankset_ctrl
    import nuca_pkg::*;
#(
    parameter int NB    = 4,
    parameter int SETS  = 4,
    parameter int TAGW  = 12,
    parameter int DATAW = 16,
    parameter int PTW   = 4,
    parameter int BASE  = 2,
    parameter int STEP  = 2,
    localparam int SETW    = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int BW      = (NB > 1) ? $clog2(NB) : 1,
    localparam int TAILLAT = BASE + (NB - 1) * STEP,
    localparam int LATW    = $clog2(TAILLAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_fill,
    input  logic [SETW-1:0]  req_set,
    input  logic [TAGW-1:0]  req_tag,
    input  logic [DATAW-1:0] req_data,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_early,
    output logic [BW-1:0]    rsp_bank,
    output logic [DATAW-1:0] rsp_data
);
    nuca_state_e state;
    logic        rsp_fire, swap_go;
    logic        accept, rd_accept, fill_accept;
    logic [SETW-1:0] rd_set, wr_set;

    logic [NB-1:0]             hit_vec;
    logic [NB-1:0]             b_valid;
    logic [NB-1:0][TAGW-1:0]   b_tag;
    logic [NB-1:0][DATAW-1:0]  b_data;

    logic [NB-1:0]             w_en;
    logic [NB-1:0]             w_valid;
    logic [NB-1:0][TAGW-1:0]   w_tag;
    logic [NB-1:0][DATAW-1:0]  w_data;
    logic [NB-1:0][PTW-1:0]    w_ptag;

    logic             pt_any;
    logic             hit_any;
    logic [BW-1:0]    hit_idx;
    logic [DATAW-1:0] hit_data;
    logic [LATW-1:0]  tgt;

    logic [SETW-1:0]  set_q;
    logic             hit_q, early_q, promote_q;
    logic [BW-1:0]    bank_q;
    logic [DATAW-1:0] data_q;

    // Handshake decode.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        accept      = req_valid && req_ready;
        rd_accept   = accept && !req_fill;
        fill_accept = accept && req_fill;
        rd_set      = (state == ST_IDLE) ? req_set : set_q;
        wr_set      = swap_go ? set_q : req_set;
    end

    // Banks and their swap/fill write muxes.
    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic             up_v, dn_v, sel_up, sel_dn, fill_here;
        logic [TAGW-1:0]  up_t, dn_t;
        logic [DATAW-1:0] up_d, dn_d;

        if (g < NB - 1) begin : g_up
            assign up_v   = b_valid[g+1];
            assign up_t   = b_tag[g+1];
            assign up_d   = b_data[g+1];
            assign sel_up = swap_go && (bank_q == BW'(g + 1));
        end else begin : g_noup
            assign up_v   = 1'b0;
            assign up_t   = '0;
            assign up_d   = '0;
            assign sel_up = 1'b0;
        end

        if (g > 0) begin : g_dn
            assign dn_v   = b_valid[g-1];
            assign dn_t   = b_tag[g-1];
            assign dn_d   = b_data[g-1];
            assign sel_dn = swap_go && (bank_q == BW'(g));
        end else begin : g_nodn
            assign dn_v   = 1'b0;
            assign dn_t   = '0;
            assign dn_d   = '0;
            assign sel_dn = 1'b0;
        end

        assign fill_here = fill_accept && (g == NB - 1);

        // Select the incoming line for this bank position.
        always_comb begin
            w_en[g] = fill_here || sel_up || sel_dn;
            if (fill_here) begin
                w_valid[g] = 1'b1;
                w_tag[g]   = req_tag;
                w_data[g]  = req_data;
            end else if (sel_up) begin
                w_valid[g] = up_v;
                w_tag[g]   = up_t;
                w_data[g]  = up_d;
            end else begin
                w_valid[g] = dn_v;
                w_tag[g]   = dn_t;
                w_data[g]  = dn_d;
            end
            w_ptag[g] = w_tag[g][PTW-1:0];
        end

        nuca_bank #(
            .SETS (SETS),
            .TAGW (TAGW),
            .DATAW(DATAW)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_set  (rd_set),
            .lk_tag  (req_tag),
            .lk_hit  (hit_vec[g]),
            .rd_valid(b_valid[g]),
            .rd_tag  (b_tag[g]),
            .rd_data (b_data[g]),
            .wr_en   (w_en[g]),
            .wr_set  (wr_set),
            .wr_valid(w_valid[g]),
            .wr_tag  (w_tag[g]),
            .wr_data (w_data[g])
        );
    end

    nuca_ptag #(
        .SETS(SETS),
        .NB  (NB),
        .PTW (PTW)
    ) u_ptag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (rd_set),
        .lk_ptag  (req_tag[PTW-1:0]),
        .any_match(pt_any),
        .wr_en    (w_en),
        .wr_set   (wr_set),
        .wr_valid (w_valid),
        .wr_ptag  (w_ptag)
    );

    // Encode the hitting bank (nearest wins) and choose the response latency.
    always_comb begin
        hit_any  = |hit_vec;
        hit_idx  = '0;
        hit_data = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx  = BW'(i);
                hit_data = b_data[i];
            end
        end
        if (hit_any) begin
            tgt = LATW'(BASE + STEP * int'(hit_idx));
        end else if (!pt_any) begin
            tgt = LATW'(1);
        end else begin
            tgt = LATW'(TAILLAT);
        end
    end

    // Capture the lookup result at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q     <= '0;
            hit_q     <= 1'b0;
            early_q   <= 1'b0;
            promote_q <= 1'b0;
            bank_q    <= '0;
            data_q    <= '0;
        end else if (rd_accept) begin
            set_q     <= req_set;
            hit_q     <= hit_any;
            early_q   <= !hit_any && !pt_any;
            promote_q <= hit_any && (hit_idx != '0);
            bank_q    <= hit_any ? hit_idx : '0;
            data_q    <= hit_any ? hit_data : '0;
        end
    end

    nuca_seq #(
        .LATW(LATW)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rd_accept),
        .tgt     (tgt),
        .promote (promote_q),
        .state   (state),
        .rsp_fire(rsp_fire),
        .swap_go (swap_go)
    );

    // Response outputs, zero outside the pulse.
    always_comb begin
        rsp_valid = rsp_fire;
        rsp_hit   = rsp_fire && hit_q;
        rsp_early = rsp_fire && early_q;
        rsp_bank  = rsp_fire ? bank_q : '0;
        rsp_data  = rsp_fire ? data_q : '0;
    end

    AST_EARLY_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_early) |-> !rsp_hit) else $error("early miss flagged a hit"); // R3
    AST_PTAG_COVERS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_accept && hit_any) |-> pt_any) else $error("partial filter missed a resident line"); // R3
    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |-> $onehot0(hit_vec)) else $error("tag present in two banks"); // R1
    AST_PROMOTE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && (rsp_bank != '0)) |=> !req_ready) else $error("no stall for swap"); // R6
    AST_BANK0_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && (rsp_bank == '0)) |=> req_ready) else $error("stall after bank0 hit"); // R5
    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fill_accept |=> (!rsp_valid && req_ready)) else $error("fill produced a response"); // R7
endmodule

// File: tb/sim_nuca_bankset_ctrl.sv
module sim_nuca_bankset_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4, SETS = 4, TAGW = 12, DATAW = 16, PTW = 4;
    localparam int BASE = 2, STEP = 2;
    localparam int TAIL = BASE + (NB - 1) * STEP;

    // Vector: fill, set, tag, data, exp_hit, exp_bank, exp_early
    localparam int NV = 20;
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 2'd1, 12'h101, 16'hA101, 1'b0, 2'd0, 1'b0}, // fill A at tail (R7)
        {1'b0, 2'd1, 12'h101, 16'h0000, 1'b1, 2'd3, 1'b0}, // A hit far bank, moves up (R4)
        {1'b1, 2'd1, 12'h202, 16'hB202, 1'b0, 2'd0, 1'b0}, // fill B
        {1'b0, 2'd1, 12'h101, 16'h0000, 1'b1, 2'd2, 1'b0}, // A climbs (R4)
        {1'b0, 2'd1, 12'h101, 16'h0000, 1'b1, 2'd1, 1'b0},
        {1'b0, 2'd1, 12'h101, 16'h0000, 1'b1, 2'd0, 1'b0}, // head hit (R5)
        {1'b1, 2'd1, 12'h303, 16'hC303, 1'b0, 2'd0, 1'b0}, // fill C evicts B (R8)
        {1'b0, 2'd1, 12'h202, 16'h0000, 1'b0, 2'd0, 1'b1}, // B gone: early miss
        {1'b0, 2'd1, 12'h303, 16'h0000, 1'b1, 2'd3, 1'b0},
        {1'b0, 2'd1, 12'h0F1, 16'h0000, 1'b0, 2'd0, 1'b0}, // partial match only (R2)
        {1'b1, 2'd1, 12'h404, 16'hD404, 1'b0, 2'd0, 1'b0},
        {1'b0, 2'd1, 12'h404, 16'h0000, 1'b1, 2'd3, 1'b0}, // D over C (R4)
        {1'b0, 2'd1, 12'h303, 16'h0000, 1'b1, 2'd3, 1'b0}, // C back over D
        {1'b0, 2'd1, 12'h303, 16'h0000, 1'b1, 2'd2, 1'b0},
        {1'b0, 2'd2, 12'h101, 16'h0000, 1'b0, 2'd0, 1'b1}, // other set empty (R9)
        {1'b1, 2'd2, 12'h505, 16'hE505, 1'b0, 2'd0, 1'b0},
        {1'b0, 2'd1, 12'h101, 16'h0000, 1'b1, 2'd0, 1'b0}, // set 1 untouched (R9)
        {1'b0, 2'd2, 12'h505, 16'h0000, 1'b1, 2'd3, 1'b0},
        {1'b0, 2'd1, 12'h303, 16'h0000, 1'b1, 2'd1, 1'b0}, // C passes A
        {1'b0, 2'd1, 12'h101, 16'h0000, 1'b1, 2'd1, 1'b0}  // A passes C back
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_fill = 1'b0;
    logic [1:0] req_set = '0;
    logic [TAGW-1:0] req_tag = '0;
    logic [DATAW-1:0] req_data = '0;
    logic req_ready, rsp_valid, rsp_hit, rsp_early;
    logic [1:0] rsp_bank;
    logic [DATAW-1:0] rsp_data;

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic             mv [SETS][NB];
    logic [TAGW-1:0]  mt [SETS][NB];
    logic [DATAW-1:0] md [SETS][NB];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nuca_bankset_ctrl #(
        .NB(NB), .SETS(SETS), .TAGW(TAGW), .DATAW(DATAW), .PTW(PTW),
        .BASE(BASE), .STEP(STEP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_fill(req_fill), .req_set(req_set), .req_tag(req_tag), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_early(rsp_early),
        .rsp_bank(rsp_bank), .rsp_data(rsp_data)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++)
            for (int p = 0; p < NB; p++) begin
                mv[s][p] = 1'b0; mt[s][p] = '0; md[s][p] = '0;
            end
    endtask

    task automatic do_fill(input int s, input logic [TAGW-1:0] t, input logic [DATAW-1:0] d);
        chk("R7 ready before fill", req_ready, 1);
        req_valid = 1'b1; req_fill = 1'b1; req_set = 2'(s); req_tag = t; req_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_fill = 1'b0;
        chk("R7 fill gives no response", rsp_valid, 0);
        chk("R7 ready after fill", req_ready, 1);
        mv[s][NB-1] = 1'b1; mt[s][NB-1] = t; md[s][NB-1] = d;
    endtask

    task automatic do_read(input int s, input logic [TAGW-1:0] t, input logic ehit,
                           input int ebank, input logic eearly);
        int pos, elat, n;
        logic ptm, tv;
        logic [TAGW-1:0] tt;
        logic [DATAW-1:0] edata, td;
        string rt;
        pos = -1; ptm = 1'b0; edata = '0;
        for (int p = 0; p < NB; p++) begin
            if (mv[s][p] && mt[s][p] == t && pos < 0) begin
                pos = p; edata = md[s][p];
            end
            if (mv[s][p] && mt[s][p][PTW-1:0] == t[PTW-1:0]) ptm = 1'b1;
        end
        elat = (pos >= 0) ? BASE + pos * STEP : (ptm ? TAIL : 1);
        rt = (pos >= 0) ? "R1" : (ptm ? "R2" : "R3");
        chk("R4 order model vs table", (pos >= 0), ehit);
        req_valid = 1'b1; req_fill = 1'b0; req_set = 2'(s); req_tag = t;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({rt, " latency"}, n, elat);
        chk({rt, " hit"}, rsp_hit, ehit);
        chk({rt, " early"}, rsp_early, eearly);
        chk({rt, " R4 bank"}, rsp_bank, ebank);
        chk({rt, " data"}, rsp_data, edata);
        @(negedge clk);
        chk({rt, " single pulse"}, rsp_valid, 0);
        if (pos > 0) begin
            chk("R6 stall during swap", req_ready, 0);
            @(negedge clk);
            chk("R6 ready after swap", req_ready, 1);
            tv = mv[s][pos]; tt = mt[s][pos]; td = md[s][pos];
            mv[s][pos] = mv[s][pos-1]; mt[s][pos] = mt[s][pos-1]; md[s][pos] = md[s][pos-1];
            mv[s][pos-1] = tv; mt[s][pos-1] = tt; md[s][pos-1] = td;
        end else begin
            chk((pos == 0) ? "R5 no stall after head hit" : "R2 ready after miss", req_ready, 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", req_ready, 1);
        chk("R10 no response after reset", rsp_valid, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][34])
                do_fill(int'(VEC[i][33:32]), VEC[i][31:20], VEC[i][19:4]);
            else
                do_read(int'(VEC[i][33:32]), VEC[i][31:20], VEC[i][3], int'(VEC[i][2:1]), VEC[i][0]);
        end

        // R8: set 1 is now [A,C,-,D]; fill F evicts D
        do_fill(1, 12'h606, 16'hF606);
        do_read(1, 12'h404, 1'b0, 0, 1'b1);
        do_read(1, 12'h606, 1'b1, 3, 1'b0);

        // R10: reset wipes all lines
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        chk("R10 ready after second reset", req_ready, 1);
        do_read(1, 12'h101, 1'b0, 0, 1'b1);
        do_read(2, 12'h505, 1'b0, 0, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule